// File: doc/BRIEF.md
# Clocked Host Controller for a 128K x 8 Asynchronous Static RAM

This block connects a synchronous host to an asynchronous byte-wide static RAM of 131,072 words. The host raises a request with a 17-bit address, a read/write flag and, for a write, one data byte. The controller then produces the memory's strobes: a select that is active low, a second select that is active high, an active-low output strobe and an active-low write strobe. It also drives a byte-wide data bus through a separate output-enable, so the pad ring decides how the bus is resolved.

Every phase length is a whole number of clock cycles. The package functions compute each length from a clock-period parameter and the memory's nanosecond limits. Each limit is rounded up to whole cycles, and no phase is shorter than one cycle. A write has three phases. The setup phase puts the address and the selects on the pins. The pulse phase holds the write strobe low while the data is driven. The hold phase raises the strobe, keeps the data on the bus for one more cycle and then releases the bus. A read selects the memory with the output strobe low and the data drivers off. It captures the byte when the access count runs out. `host_ready` is high only while the controller is idle. `host_done` pulses once at the end of each transaction.

Top module: `asram_ctl`

## Requirements
- R1: After reset and whenever idle, `host_ready`=1, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: A request is taken only in a cycle where `host_ready`=1. A request raised while the controller is busy is ignored: it leaves no trace in memory and produces no `host_done`.
- R3: During a write, `mem_oe_n` stays 1 and both selects stay active (`mem_ce_n`=0, `mem_ce`=1).
- R4: The write strobe is low for exactly max(ceil(T_PWE/CLK_NS), ceil(T_SD/CLK_NS)) cycles. The address is valid for at least ceil(T_AW/CLK_NS) cycles up to the rising edge of the strobe. The written data is stable for at least ceil(T_SD/CLK_NS) cycles before that edge.
- R5: `mem_dq_oe` is 1 in every cycle where `mem_we_n`=0. It stays 1 for exactly one cycle after `mem_we_n` rises, then drops to 0.
- R6: The strobe falls only after the selects and the address have been on the pins for a full cycle. The address stays constant while the strobe is low, and the address and selects are unchanged in the cycle the strobe rises.
- R7: `host_done` arrives setup+pulse+hold cycles after the accepting edge. Setup is max(1, ceil(T_AW)-pulse). Hold is max(1, ceil(T_WC)-setup-pulse). All values are in cycles.
- R8: A read holds `mem_oe_n`=0, the selects active, `mem_we_n`=1 and `mem_dq_oe`=0 for max(ceil(T_AA), ceil(T_RC), ceil(T_DOE)) cycles. The byte is captured at the last edge of that window. `host_done` then rises with `host_rdata` valid.
- R9: `host_done` is high for exactly one cycle per accepted request. `host_rdata` keeps the last read byte across writes and idle time.
- R10: `mem_dq_oe` and `mem_oe_n`=0 are never true in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Transaction request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Byte to write |
| host_ready | output | 1 | Idle; a request is accepted this cycle |
| host_done | output | 1 | One-cycle end-of-transaction pulse |
| host_rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Bus value driven by the controller |
| mem_dq_in | input | DATA_W | Bus value as seen at the pads |
| mem_dq_oe | output | 1 | Controller drives the bus |
| mem_ce_n | output | 1 | Active-low select |
| mem_ce | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
A phase counter loaded with the wrong value shows up within one transaction, in two places. The write-strobe width that the memory model counts comes out wrong. The `host_done` edge lands off the cycle the scoreboard predicted. If capture comes a cycle early, the read returns the model's not-yet-valid byte, which is the complement of the stored byte, so the data comparison fails on that same read. A wrong release of the bus, or a strobe that overlaps the output strobe, is caught by the model in the cycle where it happens.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WHLD = 3'd3,
    ST_RACC = 3'd4
  } phase_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = ns / clk_ns + (((ns % clk_ns) != 0) ? 1 : 0);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // strobe-low cycles: covers both the pulse width and the data setup
  function automatic int unsigned pulse_cyc(input int unsigned pwe, input int unsigned sd,
                                            input int unsigned clk_ns);
    return max2(ns_to_cyc(pwe, clk_ns), ns_to_cyc(sd, clk_ns));
  endfunction

  // address-before-strobe cycles so that address-to-end reaches the limit
  function automatic int unsigned setup_cyc(input int unsigned aw, input int unsigned pwe,
                                            input int unsigned sd, input int unsigned clk_ns);
    int unsigned a;
    int unsigned p;
    a = ns_to_cyc(aw, clk_ns);
    p = pulse_cyc(pwe, sd, clk_ns);
    return (a > p + 1) ? (a - p) : 1;
  endfunction

  // cycles after the strobe rises, padding the whole write to the cycle limit
  function automatic int unsigned hold_cyc(input int unsigned wc, input int unsigned aw,
                                           input int unsigned pwe, input int unsigned sd,
                                           input int unsigned clk_ns);
    int unsigned used;
    int unsigned w;
    used = setup_cyc(aw, pwe, sd, clk_ns) + pulse_cyc(pwe, sd, clk_ns);
    w = ns_to_cyc(wc, clk_ns);
    return (w > used + 1) ? (w - used) : 1;
  endfunction

  function automatic int unsigned read_cyc(input int unsigned aa, input int unsigned rc,
                                           input int unsigned doe, input int unsigned clk_ns);
    return max2(max2(ns_to_cyc(aa, clk_ns), ns_to_cyc(rc, clk_ns)), ns_to_cyc(doe, clk_ns));
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned SU_CYC = 1,
  parameter int unsigned WE_CYC = 1,
  parameter int unsigned HD_CYC = 1,
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             phase_end,
  output phase_t           phase,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             done,
  output logic             drive_data
);
  phase_t state, nxt;
  logic   hold_first;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    case (state)
      ST_IDLE: if (req) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (req_wr) begin
          nxt     = ST_WSET;
          tmr_val = CNT_W'(SU_CYC - 1);
        end else begin
          nxt     = ST_RACC;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_WSET: if (phase_end) begin
        nxt      = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WE_CYC - 1);
      end
      ST_WPUL: if (phase_end) begin
        nxt      = ST_WHLD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HD_CYC - 1);
      end
      ST_WHLD: if (phase_end) nxt = ST_IDLE;
      ST_RACC: if (phase_end) begin
        nxt     = ST_IDLE;
        capture = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hold_first <= 1'b0;
      done       <= 1'b0;
    end else begin
      state      <= nxt;
      hold_first <= (state == ST_WPUL) && phase_end;
      done       <= ((state == ST_WHLD) || (state == ST_RACC)) && phase_end;
    end
  end

  assign phase      = state;
  assign drive_data = (state == ST_WPUL) || ((state == ST_WHLD) && hold_first);
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= bus_in;
  end
endmodule

// File: rtl/asram_pin_decode.sv
module asram_pin_decode
  import asram_pkg::*;
(
  input  phase_t phase,
  input  logic   drive_data,
  output logic   ready,
  output logic   ce_n,
  output logic   ce,
  output logic   oe_n,
  output logic   we_n,
  output logic   dq_oe
);
  logic sel;

  always_comb begin
    sel   = (phase != ST_IDLE);
    ready = !sel;
    ce_n  = !sel;
    ce    = sel;
    oe_n  = (phase != ST_RACC);
    we_n  = (phase != ST_WPUL);
    dq_oe = drive_data;
  end
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_NS = 4,
  parameter int unsigned T_WC   = 25,
  parameter int unsigned T_AW   = 20,
  parameter int unsigned T_PWE  = 15,
  parameter int unsigned T_SD   = 12,
  parameter int unsigned T_RC   = 25,
  parameter int unsigned T_AA   = 25,
  parameter int unsigned T_DOE  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  localparam int unsigned WE_CYC = pulse_cyc(T_PWE, T_SD, CLK_NS);
  localparam int unsigned SU_CYC = setup_cyc(T_AW, T_PWE, T_SD, CLK_NS);
  localparam int unsigned HD_CYC = hold_cyc(T_WC, T_AW, T_PWE, T_SD, CLK_NS);
  localparam int unsigned RD_CYC = read_cyc(T_AA, T_RC, T_DOE, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(WE_CYC, SU_CYC), max2(HD_CYC, RD_CYC));
  localparam int unsigned CNT_W  = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  phase_t           phase;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             phase_end;
  logic             accept;
  logic             capture;
  logic             drive_data;
  logic             req_gated;

  assign req_gated = host_req;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_end)
  );

  asram_seq #(
    .SU_CYC (SU_CYC),
    .WE_CYC (WE_CYC),
    .HD_CYC (HD_CYC),
    .RD_CYC (RD_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_gated),
    .req_wr     (host_wr),
    .phase_end  (phase_end),
    .phase      (phase),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .capture    (capture),
    .done       (host_done),
    .drive_data (drive_data)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .in_addr  (host_addr),
    .in_wdata (host_wdata),
    .bus_in   (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .rdata_q  (host_rdata)
  );

  asram_pin_decode u_pins (
    .phase      (phase),
    .drive_data (drive_data),
    .ready      (host_ready),
    .ce_n       (mem_ce_n),
    .ce         (mem_ce),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe)
  );
endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int unsigned AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ready,
  input logic          host_done,
  input logic          phase_end,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dq_oe,
  input logic          mem_ce_n,
  input logic          mem_ce,
  input logic          mem_oe_n,
  input logic          mem_we_n
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_write_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_ce));

  p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  p_drive_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  p_sel_before_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_ce) && $stable(mem_addr)));

  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  p_hold_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_ce && $stable(mem_addr)));

  p_read_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && mem_ce));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> host_ready);

  p_busy_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && !phase_end) |=> !host_ready);

  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
endmodule

bind asram_ctl asram_ctl_chk #(.AW(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .host_done  (host_done),
  .phase_end  (phase_end),
  .mem_addr   (mem_addr),
  .mem_dq_oe  (mem_dq_oe),
  .mem_ce_n   (mem_ce_n),
  .mem_ce     (mem_ce),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n)
);

// File: tb/asram_ctl_test.sv
module asram_ctl_test;
  localparam int CLKP = 4;
  // bench restatement of the cycle arithmetic (ceil by addition)
  function automatic int up(input int ns);
    int r;
    r = (ns + CLKP - 1) / CLKP;
    return (r < 1) ? 1 : r;
  endfunction
  localparam int C_PWE = (15 + CLKP - 1) / CLKP;
  localparam int C_SD  = (12 + CLKP - 1) / CLKP;
  localparam int C_AW  = (20 + CLKP - 1) / CLKP;
  localparam int C_WC  = (25 + CLKP - 1) / CLKP;
  localparam int C_AA  = (25 + CLKP - 1) / CLKP;
  localparam int C_RC  = (25 + CLKP - 1) / CLKP;
  localparam int C_DOE = (9 + CLKP - 1) / CLKP;
  localparam int WE_LEN = (C_PWE > C_SD) ? C_PWE : C_SD;
  localparam int SU_LEN = (C_AW - WE_LEN > 1) ? C_AW - WE_LEN : 1;
  localparam int HD_LEN = (C_WC - SU_LEN - WE_LEN > 1) ? C_WC - SU_LEN - WE_LEN : 1;
  localparam int W_TOT  = SU_LEN + WE_LEN + HD_LEN;
  localparam int R_TOT  = (C_AA > C_RC) ? ((C_AA > C_DOE) ? C_AA : C_DOE)
                                        : ((C_RC > C_DOE) ? C_RC : C_DOE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [16:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic host_ready, host_done;
  logic [7:0] host_rdata;
  logic [16:0] mem_addr;
  logic [7:0] mem_dq_out, mem_dq_in;
  logic mem_dq_oe, mem_ce_n, mem_ce, mem_oe_n, mem_we_n;

  always #(CLKP/2) clk = ~clk;

  asram_ctl uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  int total = 0, bad = 0, cyc = 0;
  bit over = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] m_cur = 8'h00;
  int  rd_age = 0;
  bit  prev_ov = 0, rel_pending = 0;
  int  we_run = 0, dat_run = 0, addr_run = 0;
  logic [16:0] p_addr = '0;
  logic [7:0]  p_dat = '0, w_dat = '0;
  logic [16:0] w_addr = '0;
  int  clash = 0, oe_in_wr = 0, writes_seen = 0;

  wire sel_now = !mem_ce_n && mem_ce;
  wire rd_act  = sel_now && !mem_oe_n && mem_we_n;
  assign mem_dq_in = rd_act ? ((rd_age >= C_AA) ? m_cur : ~m_cur) : 8'h00;

  always @(negedge clk) if (rst_n) begin
    bit ov;
    ov = sel_now && !mem_we_n;
    if (mem_dq_oe && rd_act) clash++;
    if (ov && !mem_oe_n) oe_in_wr++;
    addr_run = (sel_now && mem_addr == p_addr) ? addr_run + 1 : (sel_now ? 1 : 0);
    dat_run  = (mem_dq_oe && mem_dq_out == p_dat) ? dat_run + 1 : (mem_dq_oe ? 1 : 0);
    if (rel_pending) begin
      chk(!mem_dq_oe, "R5 bus released two cycles after strobe rise", mem_dq_oe, 0);
      rel_pending = 0;
    end
    if (ov) begin
      we_run++;
      w_addr = mem_addr;
      w_dat  = mem_dq_out;
      if (we_run == WE_LEN) begin
        chk(dat_run >= C_SD, "R4 data setup cycles", dat_run, C_SD);
        chk(addr_run >= C_AW, "R4 address-to-end cycles", addr_run, C_AW);
      end
    end else if (prev_ov) begin
      chk(we_run == WE_LEN, "R4 strobe low length", we_run, WE_LEN);
      chk(mem_dq_oe, "R5 bus held one cycle after strobe rise", mem_dq_oe, 1);
      rel_pending = 1;
      mem[int'(w_addr)] = w_dat;
      writes_seen++;
      we_run = 0;
    end
    prev_ov = ov;
    rd_age  = rd_act ? ((mem_addr == p_addr && rd_age > 0) ? rd_age + 1 : 1) : 0;
    p_addr  = mem_addr;
    p_dat   = mem_dq_out;
    m_cur   = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
  end

  // ---------------- scoreboard ----------------
  logic [7:0] shadow [int];
  bit   q_rd[$];
  logic [7:0] q_dat[$];
  int   q_cyc[$];
  logic [7:0] last_rd = 8'h00;
  bit   prev_done = 0;

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else last_rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    q_rd.push_back(!wr);
    q_dat.push_back(last_rd);
    q_cyc.push_back(cyc + 1 + (wr ? W_TOT : R_TOT));
    @(negedge clk);
    host_req = 1'b0;
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(!(prev_done && host_done), "R9 done longer than one cycle", host_done, 0);
    if (host_done) begin
      if (q_rd.size() == 0) chk(0, "R2 done without accepted request", 1, 0);
      else begin
        bit rd; logic [7:0] ed; int ec;
        rd = q_rd.pop_front(); ed = q_dat.pop_front(); ec = q_cyc.pop_front();
        chk(cyc == ec, rd ? "R8 read latency" : "R7 write latency", cyc, ec);
        chk(host_rdata == ed, rd ? "R8 read data" : "R9 rdata kept across write",
            host_rdata, ed);
      end
    end
    prev_done = host_done;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(host_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 pins in reset", {host_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe},
        6'b110110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 idle pins", {host_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe},
        6'b110110);

    do_op(1, 17'h00000, 8'h3C);
    do_op(1, 17'h1FFFF, 8'hA5);
    do_op(1, 17'h0AAAA, 8'h00);
    do_op(1, 17'h15555, 8'hFF);
    do_op(0, 17'h00000, 8'h00);
    do_op(0, 17'h1FFFF, 8'h00);
    do_op(0, 17'h0AAAA, 8'h00);
    do_op(0, 17'h15555, 8'h00);
    do_op(0, 17'h00100, 8'h00);   // never written
    do_op(1, 17'h00042, 8'h81);   // back to back write then read
    do_op(0, 17'h00042, 8'h00);
    do_op(1, 17'h00000, 8'h7E);   // overwrite
    do_op(0, 17'h00000, 8'h00);

    // R2: request while busy must be ignored
    do_op(0, 17'h1FFFF, 8'h00);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00077; host_wdata = 8'h99;
    repeat (3) begin
      chk(!host_ready, "R2 busy during poke", host_ready, 0);
      @(negedge clk);
    end
    host_req = 1'b0;
    do_op(0, 17'h00077, 8'h00);   // expect 00: the poke must not have written

    while (q_rd.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(host_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 idle pins after traffic",
        {host_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b110110);
    chk(writes_seen == 6, "R2 number of memory writes", writes_seen, 6);
    chk(oe_in_wr == 0, "R3 output strobe low during write", oe_in_wr, 0);
    chk(clash == 0, "R10 bus contention cycles", clash, 0);
    chk(up(25) == C_AA, "R8 rounding restated", up(25), C_AA);
    if (!over) begin
      over = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!over) begin
      over = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule